// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two integer operands over several clock cycles. It keeps one partial product of twice the operand width in a register, and that register's lower half starts out holding the multiplier. On each cycle the register's least significant bit decides whether the multiplicand goes into the upper half. The register then moves right by one place, and the carry out of the addition enters at its top.

A one-cycle `start` pulse captures both operands and the sign mode. `busy` then stays high for one cycle per operand bit. On the cycle after that, `done` pulses and the full-width product appears on `hiOut` and `loOut`. In signed mode the block multiplies magnitudes and negates the result when the two operand signs differ. `hiOut` keeps its value until the next operation completes. A caller can read `hiOut` to learn whether the product fits in one word.

Top module: `shift_add_mul`

## Requirements
- R1: In unsigned mode (`signedMode`=0) the 64-bit value `{hiOut, loOut}` shown with `done` equals the unsigned product of the two 32-bit operands, including all-ones times all-ones.
- R2: The operands and `signedMode` are captured in the cycle in which `start` is accepted. Changes on `opA`, `opB` or `signedMode` while `busy` is high do not alter the product.
- R3: In signed mode (`signedMode`=1) `{hiOut, loOut}` equals the two's-complement product of the operands, including when an operand is the most negative value 0x80000000.
- R4: `busy` rises in the cycle after an accepted `start` and stays high for exactly 32 consecutive cycles, one shift-add step per cycle.
- R5: `done` is high for exactly one cycle, in the cycle right after `busy` falls, and never together with `busy`.
- R6: `hiOut` and `loOut` hold the last completed product until the next operation completes.
- R7: A `start` pulse seen while `busy` is high is ignored. The running operation keeps its timing and its operands.
- R8: When a product fits in 32 bits, `hiOut` is zero in unsigned mode and, in signed mode, equals 32 copies of `loOut[31]`.
- R9: After reset `busy` and `done` are low and `hiOut` and `loOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, one cycle |
| signedMode | input | 1 | 1: signed operands, 0: unsigned |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | 32 | Upper half of the product |
| loOut | output | 32 | Lower half of the product |

## Verification
The assertions run on every cycle and cover the iteration counter and the handshake:
- the counter advances by one on each busy cycle;
- `done` only follows the last busy cycle and lasts one cycle;
- a load clears the upper half of the partial product;
- each step shifts the lower bits right by one;
- the result holds between completions.

The numeric results are checked by the bench scenarios, which compare each product against a behavioural model. These scenarios cover:
- the arithmetic corner values;
- the sign combinations;
- a stray start while busy;
- operand changes during an iteration.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear upper half
    logic step;   // one conditional add and right shift
    logic last;   // final step: write result registers
  } mulStrobes_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output mulStrobes_t strobes
);
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OP_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] iterCnt;
  logic accept;

  assign accept = start && (state != S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (iterCnt == LAST_IDX) begin
            state   <= S_DONE;
            iterCnt <= '0;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: begin
          if (accept) begin
            state   <= S_RUN;
            iterCnt <= '0;
          end else begin
            state <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.load = accept;
    strobes.step = (state == S_RUN);
    strobes.last = (state == S_RUN) && (iterCnt == LAST_IDX);
  end

  assign busy = (state == S_RUN);
  assign done = (state == S_DONE);

  // R4: one step per busy cycle, counter advances by one
  a_r4_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iterCnt != LAST_IDX) |=> (busy && iterCnt == $past(iterCnt) + 1'b1));
  // R4: a fresh iteration starts from count zero
  a_r4_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (iterCnt == '0));
  // R5: done only directly after the last busy cycle
  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a start during busy does not restart the count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && iterCnt != LAST_IDX) |=> (iterCnt != '0));
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mulStrobes_t     strobes,
  input  logic            signedMode,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] hiOut,
  output logic [OP_W-1:0] loOut
);
  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] prodReg;
  logic [OP_W-1:0]   mcandReg;
  logic              negResult;
  logic [PROD_W-1:0] resultReg;

  logic              aNeg, bNeg;
  logic [OP_W-1:0]   magA, magB;
  logic [OP_W-1:0]   addend;
  logic [OP_W:0]     stepSum;
  logic [PROD_W-1:0] prodNext;
  logic [PROD_W-1:0] prodSigned;

  // Magnitude conversion of the incoming operands
  always_comb begin
    aNeg = signedMode && opA[OP_W-1];
    bNeg = signedMode && opB[OP_W-1];
    magA = aNeg ? (~opA + 1'b1) : opA;
    magB = bNeg ? (~opB + 1'b1) : opB;
  end

  // One shift-add step; the carry becomes the new top bit
  always_comb begin
    addend     = prodReg[0] ? mcandReg : '0;
    stepSum    = {1'b0, prodReg[PROD_W-1:OP_W]} + {1'b0, addend};
    prodNext   = {stepSum, prodReg[OP_W-1:1]};
    prodSigned = negResult ? (~prodNext + 1'b1) : prodNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prodReg   <= '0;
      mcandReg  <= '0;
      negResult <= 1'b0;
      resultReg <= '0;
    end else begin
      if (strobes.load) begin
        prodReg   <= {{OP_W{1'b0}}, magB};
        mcandReg  <= magA;
        negResult <= aNeg ^ bNeg;
      end else if (strobes.step) begin
        prodReg <= prodNext;
        if (strobes.last) begin
          resultReg <= prodSigned;
        end
      end
    end
  end

  assign hiOut = resultReg[PROD_W-1:OP_W];
  assign loOut = resultReg[OP_W-1:0];

  // R2: load clears the upper half of the partial product
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (prodReg[PROD_W-1:OP_W] == '0));
  // R4: each step moves the lower bits right by one place
  a_r4_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !strobes.load) |=> (prodReg[OP_W-2:0] == $past(prodReg[OP_W-1:1])));
  // R6: result holds except on the final step
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.last |=> $stable(resultReg));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import smul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            signedMode,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic            busy,
  output logic            done,
  output logic [OP_W-1:0] hiOut,
  output logic [OP_W-1:0] loOut
);
  mulStrobes_t strobes;

  smul_ctrl #(.OP_W(OP_W)) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .strobes (strobes)
  );

  smul_datapath #(.OP_W(OP_W)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .hiOut      (hiOut),
    .loOut      (loOut)
  );

  // R5: busy and done are never high together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  shift_add_mul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input bit sgn);
    logic [63:0] ea, eb;
    ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  // Issue start; optionally disturb inputs while busy; check timing and value
  task automatic runMul(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                        input bit disturb, input string req);
    int busyCnt = 0;
    logic [63:0] exp = model(a, b, sgn);
    @(negedge clk);
    opA = a; opB = b; signedMode = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && busyCnt < 100) begin
      busyCnt++;
      if (disturb && busyCnt == 5) begin
        opA = ~a; opB = b + 32'd3; signedMode = ~sgn; start = 1'b1;  // R7 / R2
      end else begin
        start = 1'b0;
      end
      if (disturb && busyCnt > 5) begin
        opA = a ^ 32'h5a5a_5a5a;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(busyCnt == 32, "R4 busy length", 64'(busyCnt), 64'd32);
    check(done === 1'b1, "R5 done after busy", {63'b0, done}, 64'd1);
    check({hiOut, loOut} === exp, req, {hiOut, loOut}, exp);
    @(negedge clk);
    check(done === 1'b0, "R5 done single cycle", {63'b0, done}, 64'd0);
    check({hiOut, loOut} === exp, "R6 result held", {hiOut, loOut}, exp);
  endtask

  task automatic testReset();
    check(busy === 1'b0 && done === 1'b0, "R9 reset handshake", {62'b0, busy, done}, 64'd0);
    check({hiOut, loOut} === 64'd0, "R9 reset result", {hiOut, loOut}, 64'd0);
  endtask

  task automatic testUnsignedCorners();
    runMul(32'd0, 32'hffff_ffff, 1'b0, 1'b0, "R1 zero operand");
    runMul(32'd1, 32'hdead_beef, 1'b0, 1'b0, "R1 one operand");
    runMul(32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, "R1 all ones");
    runMul(32'd7, 32'd6, 1'b0, 1'b0, "R1 small");
  endtask

  task automatic testSignedCorners();
    runMul(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R3 min times min");
    runMul(32'h8000_0000, 32'hffff_ffff, 1'b1, 1'b0, "R3 min times minus one");
    runMul(32'h8000_0000, 32'd1, 1'b1, 1'b0, "R3 min times one");
    runMul(32'hffff_fff9, 32'd2, 1'b1, 1'b0, "R3 neg times pos");
    runMul(32'd7, 32'hffff_fffe, 1'b1, 1'b0, "R3 pos times neg");
    runMul(32'hffff_fff9, 32'hffff_fffe, 1'b1, 1'b0, "R3 neg times neg");
    runMul(32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0, "R3 all ones signed");
  endtask

  task automatic testIgnoredStart();
    runMul(32'h1234_5678, 32'h9abc_def0, 1'b0, 1'b1, "R7 R2 start and inputs ignored while busy");
    runMul(32'hfedc_ba98, 32'h0000_0123, 1'b1, 1'b1, "R7 R2 signed start ignored while busy");
  endtask

  task automatic testFitsWord();
    runMul(32'hffff_fffd, 32'd100, 1'b1, 1'b0, "R8 signed small product");
    check(hiOut === {32{loOut[31]}}, "R8 hi is sign extension", {32'b0, hiOut},
          {32'b0, {32{loOut[31]}}});
    runMul(32'd1000, 32'd1000, 1'b0, 1'b0, "R8 unsigned small product");
    check(hiOut === 32'd0, "R8 hi zero unsigned", {32'b0, hiOut}, 64'd0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 24; i++) begin
      runMul($urandom, $urandom, i[0], 1'b0, i[0] ? "R3 random signed" : "R1 random unsigned");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testUnsignedCorners();
    testSignedCorners();
    testIgnoredStart();
    testFitsWord();
    testRandom();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule